// File: doc/BRIEF.md
# Complementary Gate Driver with Selectable Deadtime

This block sits between a PWM modulator and the gate drivers of a power stage. It takes up to five raw PWM bits and produces ten gate bits, grouped as five complementary pairs. Each pair has a high-side and a low-side output. A pair's two outputs are never on together. On every change of the pair's raw bit, both outputs are blanked for a programmable number of clock cycles before the newly selected side turns on.

A 3-bit application code chooses the power-stage topology. The topology sets how many pairs are live and which raw bit drives each pair. Pairs that the topology does not use are held low. A 3-bit deadtime code picks one of five blanking lengths. With a 50 MHz clock these lengths equal 40, 80, 100, 160 and 200 ns. Both codes are sampled synchronously to the clock, as are the raw PWM bits.

Top module: `gate_deadtime_driver`

## Requirements
- R1: While rst_n is low, all ten gate bits are low after the next clock edge. The first rising edge with rst_n high starts a blanking period, so an active pair's output turns on N+1 clock edges after reset is released.
- R2: The high-side bit (2k) and the low-side bit (2k+1) of pair k are never high in the same cycle.
- R3: The deadtime code maps to a blanking length N in clock cycles: code 0 gives 2, code 1 gives 4, code 2 gives 5, code 3 gives 8 and code 4 gives 10. Codes 5, 6 and 7 give 10.
- R4: When a pair's feed bit changes, the output that was on falls at the first clock edge that samples the change. The other output rises N clock periods later, which is at the (N+1)-th edge counted from that first edge. This holds for both directions of change.
- R5: A feed pulse that lasts N cycles or fewer turns on neither the high-side nor the low-side output of that pair. A pulse of exactly N+1 cycles turns the high side on for one cycle.
- R6: The application code sets the active pairs and their feeds. Code 0 (half bridge) activates pair 0 only. Code 1 (full bridge) activates pairs 0 and 1, with pair 0 fed by raw bit 0 and pair 1 fed by the inverse of raw bit 0. Code 2 (three-phase) activates pairs 0 to 2, each fed by its own raw bit. Code 3 (five-cell) activates all five pairs, each fed by its own raw bit. Codes 4 to 7 activate no pair.
- R7: The outputs of inactive pairs stay low whatever their raw bits do. In an active pair, a feed of 1 selects the high side and a feed of 0 selects the low side.
- R8: A pair that becomes active through a change of application code keeps both outputs low for a full blanking period before the selected side turns on. The selected side rises N+1 edges after the first edge that samples the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; blanking is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_raw | input | 5 | Raw PWM bits, one per pair |
| app_sel | input | 3 | Power-stage topology code |
| dt_sel | input | 3 | Deadtime length code |
| gate_out | output | 10 | Gate bits: pair k high side at 2k, low side at 2k+1 |

## Verification
The assertions treat pwm_raw, app_sel and dt_sel as synchronous inputs that are stable around each rising edge. The reset check expects rst_n to be low from time zero. The bench therefore drives every input on the falling clock edge and holds reset low before the first rising edge. It then measures blanking by counting rising edges after each stimulus. Short pulses are built as a whole number of clock cycles, so the one-cycle boundary between a suppressed pulse and a turn-on can be hit exactly.

// File: rtl/gd_pkg.sv
// Package: shared constants, topology codes and code decoders for the
// complementary gate driver. Assumes a 50 MHz clock for deadtime scaling.
package gd_pkg;

    localparam int PAIRS  = 5;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        APP_HALF  = 3'd0,
        APP_FULL  = 3'd1,
        APP_THREE = 3'd2,
        APP_FIVE  = 3'd3
    } app_e;

    // Converts a deadtime code into a blanking length in clock cycles.
    function automatic logic [CNT_W-1:0] dt_cycles(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return CNT_W'(2);
            3'd1:    return CNT_W'(4);
            3'd2:    return CNT_W'(5);
            3'd3:    return CNT_W'(8);
            default: return CNT_W'(10);
        endcase
    endfunction

    // Gives the number of pairs that a topology code turns on.
    function automatic int active_pairs(input logic [SEL_W-1:0] app);
        case (app)
            APP_HALF:  return 1;
            APP_FULL:  return 2;
            APP_THREE: return 3;
            APP_FIVE:  return 5;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/gd_pair_router.sv
// Module: decodes the topology code into per-pair enables and feed bits.
// Full bridge drives its second leg with the inverse of raw bit 0.
// Assumes the top instantiates it with PAIRS >= 2.
module gd_pair_router
    import gd_pkg::*;
#(
    parameter int N_PAIRS = PAIRS
) (
    input  logic [SEL_W-1:0]   app_sel,
    input  logic [N_PAIRS-1:0] pwm_raw,
    output logic [N_PAIRS-1:0] pair_en,
    output logic [N_PAIRS-1:0] pair_feed
);

    for (genvar k = 0; k < N_PAIRS; k++) begin : g_route
        // Enable pair k when the topology uses at least k+1 pairs.
        always_comb pair_en[k] = (k < active_pairs(app_sel));

        if (k == 1) begin : g_leg_b
            // Second leg: inverted copy of leg A in full bridge, own bit otherwise.
            always_comb pair_feed[k] = (app_sel == APP_FULL) ? ~pwm_raw[0] : pwm_raw[k];
        end else begin : g_leg_own
            // Every other pair is fed by its own raw bit.
            always_comb pair_feed[k] = pwm_raw[k];
        end
    end

endmodule

// File: rtl/gd_deadtime_leg.sv
// Module: one complementary pair with deadtime on both edges.
// A feed change, a fresh enable or reset reloads the blanking counter.
// Both outputs stay low until the counter reaches zero.
// Assumes dt_load >= 1 and inputs synchronous to clk.
module gd_deadtime_leg #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             feed,
    input  logic [CNT_W-1:0] dt_load,
    output logic             out_hi,
    output logic             out_lo
);

    logic             feed_q;
    logic             en_q;
    logic             reload;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next blanking count: reload on any edge or enable start, else count down to zero.
    always_comb begin
        reload = !en || !en_q || (feed != feed_q);
        if (reload)
            cnt_d = dt_load;
        else if (cnt_q == '0)
            cnt_d = '0;
        else
            cnt_d = cnt_q - CNT_W'(1);
    end

    // State and registered gate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feed_q <= 1'b0;
            en_q   <= 1'b0;
            cnt_q  <= dt_load;
            out_hi <= 1'b0;
            out_lo <= 1'b0;
        end else begin
            feed_q <= feed;
            en_q   <= en;
            cnt_q  <= cnt_d;
            out_hi <= en && (cnt_d == '0) && feed;
            out_lo <= en && (cnt_d == '0) && !feed;
        end
    end

    // R2: the two sides never conduct together.
    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hi && out_lo));

    // R4: an edge on the feed blanks both outputs at the next edge.
    a_r4_edge_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_q && (feed != feed_q)) |=> (!out_hi && !out_lo));

    // R5: the high side only turns on after the low side was already off.
    a_r5_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_hi) |-> !$past(out_lo));

    // R7: a disabled pair drives nothing.
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!out_hi && !out_lo));

    // R1: reset forces both outputs low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!out_hi && !out_lo));

endmodule

// File: rtl/gate_deadtime_driver.sv
// Module: top of the complementary gate driver. Routes raw PWM bits to
// pairs by topology and inserts the selected deadtime in each pair.
// Assumes a 50 MHz clock so the deadtime codes equal 40..200 ns.
module gate_deadtime_driver
    import gd_pkg::*;
#(
    parameter int N_PAIRS = PAIRS,
    parameter int DT_W    = CNT_W,
    localparam int OUT_W  = 2 * N_PAIRS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PAIRS-1:0] pwm_raw,
    input  logic [SEL_W-1:0]   app_sel,
    input  logic [SEL_W-1:0]   dt_sel,
    output logic [OUT_W-1:0]   gate_out
);

    logic [N_PAIRS-1:0] pair_en;
    logic [N_PAIRS-1:0] pair_feed;
    logic [N_PAIRS-1:0] side_hi;
    logic [N_PAIRS-1:0] side_lo;
    logic [DT_W-1:0]    dt_len;

    // Deadtime code to cycle count.
    always_comb dt_len = DT_W'(dt_cycles(dt_sel));

    gd_pair_router #(.N_PAIRS(N_PAIRS)) u_router (
        .app_sel   (app_sel),
        .pwm_raw   (pwm_raw),
        .pair_en   (pair_en),
        .pair_feed (pair_feed)
    );

    for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
        gd_deadtime_leg #(.CNT_W(DT_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (pair_en[k]),
            .feed    (pair_feed[k]),
            .dt_load (dt_len),
            .out_hi  (side_hi[k]),
            .out_lo  (side_lo[k])
        );
        // Pack the pair: high side on the even bit, low side on the odd bit.
        assign gate_out[2*k]   = side_hi[k];
        assign gate_out[2*k+1] = side_lo[k];
    end

    // R7: pairs the topology leaves unused stay low at the ports.
    a_r7_unused_pairs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (app_sel == APP_HALF) |=> (gate_out[OUT_W-1:2] == '0));

    // R6: undefined topology codes silence every output.
    a_r6_no_topology_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active_pairs(app_sel) == 0) |=> (gate_out == '0));

endmodule

// File: tb/gate_deadtime_driver_tb.sv
module gate_deadtime_driver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pwm_raw = '0;
    logic [2:0] app_sel = 3'd0;
    logic [2:0] dt_sel = 3'd0;
    logic [9:0] gate_out;

    int checks = 0;
    int failures = 0;
    int overlap_seen = 0;
    int hi0_count = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gate_deadtime_driver u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_raw  (pwm_raw),
        .app_sel  (app_sel),
        .dt_sel   (dt_sel),
        .gate_out (gate_out)
    );

    // Monitor for R2 and for counting high-side pulses of pair 0.
    always @(negedge clk) begin
        for (int k = 0; k < 5; k++)
            if (rst_n && gate_out[2*k] && gate_out[2*k+1]) overlap_seen++;
        if (gate_out[0]) hi0_count++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int dt_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 5;
            3: return 8;
            default: return 10;
        endcase
    endfunction

    // Counts rising edges until gate bit b goes high (input already changed).
    task automatic edges_until(input int b, output int n);
        n = 0;
        while (n < 40) begin
            @(posedge clk); #1;
            n++;
            if (gate_out[b]) break;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state and first blanking after release.
    task automatic t_reset();
        int n;
        app_sel = 3'd0; dt_sel = 3'd0; pwm_raw = '0;
        rst_n = 1'b0;
        settle(3);
        chk("R1 reset outputs", gate_out, 10'h000);
        rst_n = 1'b1;
        edges_until(1, n);
        chk("R1 first turn-on edges", n, dt_of(0) + 1);
    endtask

    // R3/R4: every deadtime code, rising feed; check fall of old side too.
    task automatic t_codes();
        int n;
        app_sel = 3'd0;
        for (int c = 0; c < 8; c++) begin
            dt_sel = 3'(c); pwm_raw = '0;
            settle(15);
            pwm_raw[0] = 1'b1;
            @(posedge clk); #1;
            chk("R4 old side falls at first edge", gate_out[1:0], 2'b00);
            edges_until(0, n);
            chk($sformatf("R3 code %0d rise edges", c), n + 1, dt_of(c) + 1);
        end
        // R4: falling direction with code 2.
        dt_sel = 3'd2;
        settle(15);
        @(negedge clk); pwm_raw[0] = 1'b0;
        edges_until(1, n);
        chk("R4 low side rise edges", n, dt_of(2) + 1);
    endtask

    // R5: pulses at and just above the deadtime.
    task automatic t_short_pulse();
        dt_sel = 3'd1; app_sel = 3'd0; pwm_raw = '0;
        settle(15);
        hi0_count = 0;
        pwm_raw[0] = 1'b1;
        settle(dt_of(1));
        pwm_raw[0] = 1'b0;
        settle(20);
        chk("R5 pulse of N suppressed", hi0_count, 0);
        chk("R5 low side back", gate_out[1], 1'b1);
        hi0_count = 0;
        pwm_raw[0] = 1'b1;
        settle(dt_of(1) + 1);
        pwm_raw[0] = 1'b0;
        settle(20);
        chk("R5 pulse of N+1 one cycle", hi0_count, 1);
    endtask

    // R6: each topology code with a fixed raw pattern.
    task automatic t_apps();
        dt_sel = 3'd0;
        pwm_raw = 5'b11111; app_sel = 3'd0; settle(15);
        chk("R6 half bridge", gate_out, 10'h001);
        pwm_raw = 5'b00001; app_sel = 3'd1; settle(15);
        chk("R6 full bridge raw0=1", gate_out, 10'h009);
        pwm_raw = 5'b00000; settle(15);
        chk("R6 full bridge raw0=0", gate_out, 10'h006);
        pwm_raw = 5'b10101; app_sel = 3'd2; settle(15);
        chk("R6 three-phase", gate_out, 10'h019);
        app_sel = 3'd3; settle(15);
        chk("R6 five-cell", gate_out, 10'h199);
        app_sel = 3'd6; settle(15);
        chk("R6 unused code", gate_out, 10'h000);
    endtask

    // R7: toggling raw bits of unused pairs in three-phase mode.
    task automatic t_inactive();
        int bad = 0;
        dt_sel = 3'd0; app_sel = 3'd2; pwm_raw = '0;
        settle(15);
        for (int i = 0; i < 20; i++) begin
            pwm_raw[4:3] = 2'(i);
            @(negedge clk);
            if (gate_out[9:6] != 4'h0 || gate_out[5:0] != 6'b101010) bad++;
        end
        chk("R7 unused pairs stay low", bad, 0);
    endtask

    // R8: enabling a pair through the topology code.
    task automatic t_enable();
        int n;
        dt_sel = 3'd3; app_sel = 3'd5; pwm_raw = '0;
        settle(15);
        chk("R8 no pair before enable", gate_out, 10'h000);
        app_sel = 3'd0;
        edges_until(1, n);
        chk("R8 enable blanking edges", n, dt_of(3) + 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_codes();
        @(negedge clk);
        t_short_pulse();
        t_apps();
        t_inactive();
        t_enable();
        settle(2);
        chk("R2 no overlap seen", overlap_seen, 0);
        finish_run();
    end

endmodule